// File: doc/BRIEF.md
# Set-Associative Tag Lookup with LRU and Access-Energy Counters

This block holds the tags and valid bits of a set-associative cache. It answers lookups with hit, hit way and the least-recently-used way of the addressed set. It accepts fills that write one tag into a chosen way. Replacement order is true LRU, kept as a per-set rank for each way. Hits and fills both make their way the most recently used.

Beside the lookup path, two saturating counters record how many tag-array entries and data-array entries were touched. Power models read them. The counters can be cleared synchronously.

A static mode input chooses how the data array is assumed to be read:
- In parallel mode, every way's data is read alongside the tags.
- In sequential mode, data is read only after a tag hit, and then from one way only.

The geometry is set by parameters. The set count is the cache size divided by the block size times the way count. Elaboration fails if any of these hold:
- the block size is not a power of two;
- the block size is below 4 bytes;
- the set count is not a power of two of at least 2;
- there are fewer than 2 ways.

Top module: `lru_tag_store`

## Requirements
- R1: `hit_o` is 1 in the same cycle as a counted lookup whose tag matches a valid way of the indexed set. `hit_way_o` then gives that way, the lowest-numbered one if several match. With no hit, `hit_o` and `hit_way_o` are 0.
- R2: The low log2(BLOCK_BYTES) address bits are ignored. The next log2(SETS) bits select the set, and all higher bits form the tag. With the defaults these are bits [3:0], [7:4] and [31:8].
- R3: Each counted lookup adds WAYS to `tag_cnt_o` on the next clock edge.
- R4: With `seq_mode_i` = 0 (parallel), each counted lookup adds WAYS to `data_cnt_o`, whether it hits or misses.
- R5: With `seq_mode_i` = 1 (sequential), a counted lookup that hits adds 1 to `data_cnt_o`, and one that misses adds 0.
- R6: An insert adds exactly 1 to `tag_cnt_o` and 1 to `data_cnt_o`. It marks the way `ins_way_i` of the indexed set valid with the insert address's tag.
- R7: A lookup hit makes the hit way most recently used in its set. `victim_way_o` always shows the least recently used way of the set indexed by `lkp_addr_i`. After reset, way k has recency rank k, so the victim of every set is way WAYS-1.
- R8: An inserted way becomes most recently used in its set.
- R9: When `ins_valid_i` and `lkp_valid_i` are both 1, the lookup is ignored. It gives no hit, adds nothing to either counter, and changes no recency order.
- R10: Both counters saturate at all ones and never wrap.
- R11: `cnt_clr_i` sets both counters to 0 on the next edge, overriding any increment in that cycle.
- R12: After reset both counters are 0 and every way is invalid, so no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_mode_i | input | 1 | 0 = parallel tag/data read, 1 = sequential |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_addr_i | input | ADDR_W | Lookup address |
| ins_valid_i | input | 1 | Insert (fill) request |
| ins_addr_i | input | ADDR_W | Insert address |
| ins_way_i | input | log2(WAYS) | Way to write on insert |
| cnt_clr_i | input | 1 | Synchronous clear of both counters |
| hit_o | output | 1 | Lookup hit |
| hit_way_o | output | log2(WAYS) | Way that hit |
| victim_way_o | output | log2(WAYS) | LRU way of the set indexed by `lkp_addr_i` |
| tag_cnt_o | output | CNT_W | Tag-array access count |
| data_cnt_o | output | CNT_W | Data-array access count |

## Verification
The assertions watch the counter arithmetic on every cycle:
- an increment of WAYS per counted lookup;
- an increment of one per fill;
- a flat data count on a sequential miss;
- zero after a clear;
- no wraparound.

They also check that a hit never appears without a counted lookup. Whether a hit is correct, which way it names, and how recency ranks move after hits, fills and ignored lookups depend on history. Only the bench's reference model shows these. It runs directed sequences on one set and a long random mix with mode changes and clears. A narrowed counter width lets saturation be reached within the run.

// File: rtl/lru_tag_pkg.sv
package lru_tag_pkg;

  typedef enum logic {
    ACC_PARALLEL   = 1'b0,
    ACC_SEQUENTIAL = 1'b1
  } acc_mode_e;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/tag_way_array.sv
module tag_way_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic [WAYS-1:0]  match_o
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             wr_sel;

    assign wr_sel = wr_en_i && (wr_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
      end else if (wr_sel) begin
        vld_q[wr_idx_i] <= 1'b1;
      end
    end

    // tag storage needs no reset: gated by valid
    always_ff @(posedge clk_i) begin
      if (wr_sel) begin
        tag_q[wr_idx_i] <= wr_tag_i;
      end
    end

    assign match_o[w] = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  end

endmodule

// File: rtl/lru_rank_table.sv
module lru_rank_table #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WAY_W-1:0] victim_way_o
);

  logic [SETS-1:0][WAY_W-1:0] set_lru;

  // rank 0 = MRU, rank WAYS-1 = LRU
  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAY_W-1:0] rank_q [WAYS];
    logic [WAY_W-1:0] pivot;
    logic [WAY_W-1:0] lru_way;

    assign pivot = rank_q[upd_way_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WAYS; w++) rank_q[w] <= WAY_W'(w);
      end else if (upd_en_i && (upd_idx_i == IDX_W'(s))) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == upd_way_i) begin
            rank_q[w] <= '0;
          end else if (rank_q[w] < pivot) begin
            rank_q[w] <= rank_q[w] + 1'b1;
          end
        end
      end
    end

    always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++) begin
        if (rank_q[w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
      end
    end

    assign set_lru[s] = lru_way;
  end

  assign victim_way_o = set_lru[rd_idx_i];

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] cnt_d;

  assign sum   = {1'b0, cnt_q} + SUM_W'(inc_i);
  assign cnt_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/lru_tag_store.sv
module lru_tag_store
  import lru_tag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int CNT_W       = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    seq_mode_i,
  input  logic                    lkp_valid_i,
  input  logic [ADDR_W-1:0]       lkp_addr_i,
  input  logic                    ins_valid_i,
  input  logic [ADDR_W-1:0]       ins_addr_i,
  input  logic [$clog2(WAYS)-1:0] ins_way_i,
  input  logic                    cnt_clr_i,
  output logic                    hit_o,
  output logic [$clog2(WAYS)-1:0] hit_way_o,
  output logic [$clog2(WAYS)-1:0] victim_way_o,
  output logic [CNT_W-1:0]        tag_cnt_o,
  output logic [CNT_W-1:0]        data_cnt_o
);

  localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int INC_W = $clog2(WAYS + 1);

  if (!is_pow2(BLOCK_BYTES) || BLOCK_BYTES < 4) begin : g_bad_block
    $error("lru_tag_store: block size must be a power of two and at least 4");
  end
  if (!is_pow2(SETS) || SETS < 2 || WAYS < 2) begin : g_bad_geom
    $error("lru_tag_store: set count must be a power of two >= 2, ways >= 2");
  end

  acc_mode_e        mode;
  logic [IDX_W-1:0] lkp_idx, ins_idx;
  logic [TAG_W-1:0] lkp_tag, ins_tag;
  logic             lkp_go;
  logic [WAYS-1:0]  match;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  logic [WAY_W-1:0] upd_way;
  logic [INC_W-1:0] tag_inc, data_inc;
  logic             unused_off;

  assign mode    = acc_mode_e'(seq_mode_i);
  assign lkp_idx = lkp_addr_i[OFF_W +: IDX_W];
  assign lkp_tag = lkp_addr_i[ADDR_W-1 -: TAG_W];
  assign ins_idx = ins_addr_i[OFF_W +: IDX_W];
  assign ins_tag = ins_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_off = ^{lkp_addr_i[OFF_W-1:0], ins_addr_i[OFF_W-1:0]};

  // insert wins; a colliding lookup is dropped entirely
  assign lkp_go = lkp_valid_i && !ins_valid_i;

  tag_way_array #(
    .SETS (SETS),
    .WAYS (WAYS),
    .TAG_W(TAG_W)
  ) i_tag_way_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (ins_valid_i),
    .wr_idx_i(ins_idx),
    .wr_way_i(ins_way_i),
    .wr_tag_i(ins_tag),
    .rd_idx_i(lkp_idx),
    .rd_tag_i(lkp_tag),
    .match_o (match)
  );

  assign hit = lkp_go && (|match);

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign upd_en  = ins_valid_i || hit;
  assign upd_idx = ins_valid_i ? ins_idx : lkp_idx;
  assign upd_way = ins_valid_i ? ins_way_i : hit_way;

  lru_rank_table #(
    .SETS(SETS),
    .WAYS(WAYS)
  ) i_lru_rank_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_en_i    (upd_en),
    .upd_idx_i   (upd_idx),
    .upd_way_i   (upd_way),
    .rd_idx_i    (lkp_idx),
    .victim_way_o(victim_way_o)
  );

  always_comb begin
    tag_inc  = '0;
    data_inc = '0;
    if (ins_valid_i) begin
      tag_inc  = INC_W'(1);
      data_inc = INC_W'(1);
    end else if (lkp_valid_i) begin
      tag_inc = INC_W'(WAYS);
      if (mode == ACC_PARALLEL) begin
        data_inc = INC_W'(WAYS);
      end else begin
        data_inc = hit ? INC_W'(1) : '0;
      end
    end
  end

  sat_counter #(
    .CNT_W(CNT_W),
    .INC_W(INC_W)
  ) i_tag_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr_i),
    .inc_i (tag_inc),
    .cnt_o (tag_cnt_o)
  );

  sat_counter #(
    .CNT_W(CNT_W),
    .INC_W(INC_W)
  ) i_data_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr_i),
    .inc_i (data_inc),
    .cnt_o (data_cnt_o)
  );

  assign hit_o     = hit;
  assign hit_way_o = hit ? hit_way : '0;

endmodule

// File: rtl/lru_tag_store_chk.sv
module lru_tag_store_chk #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seq_mode_i,
  input logic             lkp_valid_i,
  input logic             ins_valid_i,
  input logic             cnt_clr_i,
  input logic             hit_o,
  input logic [CNT_W-1:0] tag_cnt_o,
  input logic [CNT_W-1:0] data_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] STEP     = CNT_W'(WAYS);
  localparam logic [CNT_W-1:0] STEP_TOP = CNT_MAX - STEP;

  AST_HIT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (lkp_valid_i && !ins_valid_i)); // R9

  AST_TAG_LOOKUP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && lkp_valid_i && !ins_valid_i && tag_cnt_o <= STEP_TOP)
    |=> tag_cnt_o == $past(tag_cnt_o) + STEP); // R3

  AST_PAR_DATA_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && !seq_mode_i && lkp_valid_i && !ins_valid_i && data_cnt_o <= STEP_TOP)
    |=> data_cnt_o == $past(data_cnt_o) + STEP); // R4

  AST_SEQ_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && seq_mode_i && lkp_valid_i && !ins_valid_i && !hit_o)
    |=> $stable(data_cnt_o)); // R5

  AST_INSERT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_clr_i && ins_valid_i && tag_cnt_o != CNT_MAX && data_cnt_o != CNT_MAX)
    |=> (tag_cnt_o == $past(tag_cnt_o) + 1'b1) && (data_cnt_o == $past(data_cnt_o) + 1'b1)); // R6

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clr_i |=> (tag_cnt_o >= $past(tag_cnt_o)) && (data_cnt_o >= $past(data_cnt_o))); // R10

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (tag_cnt_o == '0) && (data_cnt_o == '0)); // R11

endmodule

bind lru_tag_store lru_tag_store_chk #(
  .WAYS (WAYS),
  .CNT_W(CNT_W)
) i_chk (.*);

// File: tb/test_lru_tag_store.sv
`timescale 1ns/1ps
module test_lru_tag_store;

  localparam int SETS  = 16;
  localparam int WAYS  = 4;
  localparam int CNT_W = 8;
  localparam int CMAX  = 255;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        seq_mode = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_addr = '0;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_addr = '0;
  logic [1:0]  ins_way = '0;
  logic        cnt_clr = 1'b0;
  logic        hit;
  logic [1:0]  hit_way;
  logic [1:0]  victim_way;
  logic [CNT_W-1:0] tag_cnt;
  logic [CNT_W-1:0] data_cnt;

  int n_chk = 0;
  int n_fail = 0;

  // reference model: MRU-first order list per set
  int ord [SETS][WAYS];
  int tag_m [SETS][WAYS];
  bit vld_m [SETS][WAYS];
  int tcnt_m = 0;
  int dcnt_m = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  lru_tag_store #(
    .ADDR_W(32),
    .CACHE_BYTES(1024),
    .BLOCK_BYTES(16),
    .WAYS(WAYS),
    .CNT_W(CNT_W)
  ) i_lru_tag_store (
    .clk_i(clk), .rst_ni(rst_ni), .seq_mode_i(seq_mode),
    .lkp_valid_i(lkp_valid), .lkp_addr_i(lkp_addr),
    .ins_valid_i(ins_valid), .ins_addr_i(ins_addr), .ins_way_i(ins_way),
    .cnt_clr_i(cnt_clr), .hit_o(hit), .hit_way_o(hit_way),
    .victim_way_o(victim_way), .tag_cnt_o(tag_cnt), .data_cnt_o(data_cnt)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic promote(input int s, input int w);
    int p = 0;
    for (int k = 0; k < WAYS; k++) if (ord[s][k] == w) p = k;
    for (int k = p; k > 0; k--) ord[s][k] = ord[s][k-1];
    ord[s][0] = w;
  endtask

  function automatic int sat(input int v, input int inc);
    return (v + inc > CMAX) ? CMAX : v + inc;
  endfunction

  // starts and ends at a falling edge
  task automatic do_cycle(input bit lv, input logic [31:0] la, input bit iv,
                          input logic [31:0] ia, input int iw, input bit clr);
    int li, lt, ii, it, ew, ev, tinc, dinc;
    bit go, eh;
    lkp_valid = lv; lkp_addr = la; ins_valid = iv; ins_addr = ia;
    ins_way = 2'(iw); cnt_clr = clr;
    #1;
    li = int'((la >> 4) & 32'hF); lt = int'(la >> 8);
    ii = int'((ia >> 4) & 32'hF); it = int'(ia >> 8);
    go = lv && !iv;
    eh = 1'b0; ew = 0;
    if (go) begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (vld_m[li][w] && tag_m[li][w] == lt) begin eh = 1'b1; ew = w; end
    end
    ev = ord[li][WAYS-1];
    chk(iv && lv ? "R9" : "R1", "hit", int'(hit), int'(eh));
    chk("R1", "hit_way", int'(hit_way), eh ? ew : 0);
    chk("R7", "victim", int'(victim_way), ev);
    @(posedge clk);
    tinc = iv ? 1 : (go ? WAYS : 0);
    dinc = iv ? 1 : (go ? (seq_mode ? (eh ? 1 : 0) : WAYS) : 0);
    if (clr) begin tcnt_m = 0; dcnt_m = 0; end
    else begin tcnt_m = sat(tcnt_m, tinc); dcnt_m = sat(dcnt_m, dinc); end
    if (iv) begin
      vld_m[ii][iw] = 1'b1; tag_m[ii][iw] = it; promote(ii, iw);
    end else if (eh) begin
      promote(li, ew);
    end
    @(negedge clk);
    chk(clr ? "R11" : iv ? "R6" : (tcnt_m == CMAX) ? "R10" : "R3", "tag_cnt", int'(tag_cnt), tcnt_m);
    chk(clr ? "R11" : iv ? "R6" : (dcnt_m == CMAX) ? "R10" : seq_mode ? "R5" : "R4",
        "data_cnt", int'(data_cnt), dcnt_m);
  endtask

  localparam logic [31:0] A_ADR = 32'h0000_1010;
  localparam logic [31:0] B_ADR = 32'h0000_2010;
  localparam logic [31:0] C_ADR = 32'h0000_3010;
  localparam logic [31:0] D_ADR = 32'h0000_4010;
  localparam logic [31:0] E_ADR = 32'h0000_5010;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        ord[s][w] = w; vld_m[s][w] = 1'b0; tag_m[s][w] = 0;
      end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12: reset state
    lkp_valid = 1'b1; lkp_addr = A_ADR; #1;
    chk("R12", "tag_cnt", int'(tag_cnt), 0);
    chk("R12", "data_cnt", int'(data_cnt), 0);
    chk("R12", "hit", int'(hit), 0);
    chk("R7", "reset victim", int'(victim_way), WAYS - 1);
    @(negedge clk);
    tcnt_m = WAYS; dcnt_m = WAYS;

    // parallel mode
    seq_mode = 1'b0;
    do_cycle(1, A_ADR, 0, '0, 0, 0);            // R4 miss counts all ways
    do_cycle(0, '0, 1, A_ADR, 3, 0);            // R6 insert into way 3
    do_cycle(1, A_ADR, 0, '0, 0, 0);            // R1 hit way 3
    do_cycle(1, A_ADR | 32'hC, 0, '0, 0, 0);    // R2 offset ignored
    do_cycle(1, 32'h0000_1020, 0, '0, 0, 0);    // R2 other set misses
    do_cycle(1, 32'h0001_0010, 0, '0, 0, 0);    // R2 other tag misses
    do_cycle(0, '0, 1, B_ADR, 0, 0);            // R8
    do_cycle(0, '0, 1, C_ADR, 1, 0);
    do_cycle(0, '0, 1, D_ADR, 2, 0);
    do_cycle(1, B_ADR, 0, '0, 0, 0);            // R7 victim before/after promote
    do_cycle(1, A_ADR, 0, '0, 0, 0);
    do_cycle(1, C_ADR, 0, '0, 0, 0);

    // sequential mode
    seq_mode = 1'b1;
    do_cycle(1, D_ADR, 0, '0, 0, 0);            // R5 hit adds one
    do_cycle(1, E_ADR, 0, '0, 0, 0);            // R5 miss adds none
    do_cycle(1, C_ADR, 1, E_ADR, 0, 0);         // R9 collision
    do_cycle(1, C_ADR, 0, '0, 0, 0);            // R9 order untouched by dropped lookup
    do_cycle(1, E_ADR, 0, '0, 0, 0);
    do_cycle(1, A_ADR, 0, '0, 0, 1);            // R11 clear beats increment
    do_cycle(0, '0, 0, '0, 0, 0);

    // R10 saturation
    seq_mode = 1'b0;
    for (int i = 0; i < 80; i++) do_cycle(1, E_ADR ^ 32'h100, 0, '0, 0, 0);
    do_cycle(0, '0, 1, 32'h0000_7070, 1, 0);
    do_cycle(1, A_ADR, 0, '0, 0, 1);            // R11

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] la, ia;
      if (i % 200 == 0) seq_mode = ~seq_mode;
      la = (($urandom % 6) << 8) | (($urandom % 4) << 4) | ($urandom % 16);
      ia = (($urandom % 6) << 8) | (($urandom % 4) << 4) | ($urandom % 16);
      do_cycle(bit'($urandom % 2), la, ($urandom % 5) == 0, ia,
               int'($urandom % WAYS), ($urandom % 97) == 0);
    end

    summary();
    $finish;
  end

endmodule